// File: doc/BRIEF.md
# Write Data Mirroring Bridge

This block sits between a host-side write port and a 32-bit big-endian peripheral bus. It serves two kinds of slave. Some slaves decode byte enables. Others are narrow and ignore them, reading only the low-numbered lanes. For each write the block takes a word, an address and a transfer size, which may be one, two, three or four bytes. It then drives the byte-enable vector for that access. It places every active byte in its natural lane, and it also copies bytes into lanes 0 and 1 where a narrow slave expects to find them. The address, enables and data are registered and presented with a valid/ready handshake.

A small bank of lane-order select registers lets software permute bytes. There is one select per transfer size for the write path, applied to the host word before mirroring. There is one select per transfer size for the read path, applied to the raw read word coming back from the bus. Each select holds a 2-bit source-lane index for each output lane. A request with an impossible size and offset pair is consumed, produces no bus beat, and raises a one-cycle error pulse.

Top module: `wmirror_bridge`

## Requirements
- R1: Lane k occupies bus bits [31-8k -: 8], and `bus_be[3-k]` enables lane k. A four-byte write at offset 0 drives enables 1111 with bytes 0..3 in lanes 0..3. A three-byte write (size code 2) at offset 0 drives 1110 with lane 3 zero. A three-byte write at offset 1 drives 0111, with byte 1 also copied into lane 0.
- R2: A two-byte write (size code 1) at offset 0 drives enables 1100 with bytes 0 and 1 in lanes 0 and 1. At offset 2 it drives 0011, with bytes 2 and 3 in lanes 2 and 3 and also copied into lanes 0 and 1.
- R3: A one-byte write (size code 0) at offset n drives a single enable for lane n, with the byte in its own lane. It also copies the byte into lane 0 when n is nonzero, and into lane 1 as well when n is 3.
- R4: Every lane that is neither enabled nor carrying a mirrored copy is driven to zero.
- R5: A request is legal only when offset plus length is at most 4 and it is not a two-byte write at an odd offset. An illegal request is consumed. In the cycle after acceptance `req_err` is 1 and `bus_valid` is 0. `req_err` is 0 in every other cycle.
- R6: While `bus_valid` is 1 and `bus_ready` is 0, the bus address, enables and data hold their values.
- R7: `req_ready` is 1 exactly when the output stage is empty or is draining in the same cycle. A request and a drain in the same cycle hand over without a bubble.
- R8: `bus_addr` repeats the accepted request address, and its two low bits give the lane offset.
- R9: Bank entries 0..3, indexed by size code, permute the host word before mirroring. Output lane k takes source lane `sel[2k+1:2k]`.
- R10: Bank entries 4..7, indexed by 4 plus the size code on `rd_size`, permute `rd_raw` into `rd_data` with the same field layout.
- R11: After reset every select is the identity value 0xE4, `bus_valid` and `req_err` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host write request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | ADDR_W | Byte address of the write |
| req_size | input | 2 | Size code: 0 one byte, 1 two, 2 three, 3 four |
| req_data | input | 32 | Host word, byte k in lane k |
| req_err | output | 1 | One-cycle pulse for an illegal request |
| bus_valid | output | 1 | Bus beat present |
| bus_ready | input | 1 | Bus takes the beat |
| bus_addr | output | ADDR_W | Registered address of the beat |
| bus_be | output | 4 | Byte enables, bit 3 for lane 0 |
| bus_data | output | 32 | Mirrored write data |
| cfg_we | input | 1 | Select register write strobe |
| cfg_addr | input | 3 | Select entry: bit 2 picks the read bank, bits 1:0 the size |
| cfg_wdata | input | 8 | New select value |
| rd_size | input | 2 | Size code of the read being returned |
| rd_raw | input | 32 | Raw read word from the bus |
| rd_data | output | 32 | Permuted read word |

## Verification
The assertions assume that `req_valid`, `req_size` and `bus_ready` are known at every sampled edge after reset. They also assume that the bus side may hold `bus_ready` low for any length of time. The bench drives every input on the falling clock edge, so each value is stable at the rising edge. It sweeps all sixteen size and offset pairs, legal and illegal, with several data words, under both identity and reversing write selects. Stalls are produced only by lowering `bus_ready` while a beat is held, with a second request waiting at the input.

// File: rtl/wmb_pkg.sv
package wmb_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int BUS_W  = LANES * LANE_W;
  localparam int SEL_W  = $clog2(LANES);
  localparam int CFG_W  = LANES * SEL_W;
  localparam int NUM_SIZES = 4;
  localparam int NUM_SEL   = 2 * NUM_SIZES;

  typedef enum logic [1:0] {
    SZ_ONE   = 2'd0,
    SZ_TWO   = 2'd1,
    SZ_THREE = 2'd2,
    SZ_FOUR  = 2'd3
  } xfer_size_e;

  localparam logic [CFG_W-1:0] IDENTITY_SEL = 8'hE4;

  function automatic logic [LANE_W-1:0] lane_of(input logic [BUS_W-1:0] w, input int k);
    return w[BUS_W-1-LANE_W*k -: LANE_W];
  endfunction
endpackage

// File: rtl/wmb_lane_perm.sv
module wmb_lane_perm
  import wmb_pkg::*;
(
  input  logic [BUS_W-1:0] din,
  input  logic [CFG_W-1:0] sel,
  output logic [BUS_W-1:0] dout
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SEL_W-1:0] src;
    assign src = sel[SEL_W*k +: SEL_W];
    assign dout[BUS_W-1-LANE_W*k -: LANE_W] = lane_of(din, int'(src));
  end
endmodule

// File: rtl/wmb_sel_bank.sv
module wmb_sel_bank
  import wmb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [1:0]       wr_size,
  input  logic [1:0]       rd_size,
  output logic [CFG_W-1:0] wr_sel,
  output logic [CFG_W-1:0] rd_sel
);
  logic [CFG_W-1:0] sel_q [NUM_SEL];

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_entry
    logic en;
    assign en = cfg_we && (cfg_addr == 3'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q[i] <= IDENTITY_SEL;
      else if (en) sel_q[i] <= cfg_wdata;
    end
  end

  assign wr_sel = sel_q[{1'b0, wr_size}];
  assign rd_sel = sel_q[{1'b1, rd_size}];
endmodule

// File: rtl/wmb_mirror.sv
module wmb_mirror
  import wmb_pkg::*;
(
  input  xfer_size_e       size,
  input  logic [1:0]       offs,
  input  logic [BUS_W-1:0] data,
  output logic             legal,
  output logic [LANES-1:0] be,
  output logic [BUS_W-1:0] mdata
);
  logic [LANE_W-1:0] b0, b1, b2, b3;
  localparam logic [LANE_W-1:0] Z = '0;

  assign b0 = lane_of(data, 0);
  assign b1 = lane_of(data, 1);
  assign b2 = lane_of(data, 2);
  assign b3 = lane_of(data, 3);

  always_comb begin
    legal = 1'b1;
    be    = 4'b0000;
    mdata = '0;
    unique case ({size, offs})
      {SZ_FOUR,  2'd0}: begin be = 4'b1111; mdata = {b0, b1, b2, b3}; end
      {SZ_THREE, 2'd0}: begin be = 4'b1110; mdata = {b0, b1, b2, Z};  end
      {SZ_THREE, 2'd1}: begin be = 4'b0111; mdata = {b1, b1, b2, b3}; end
      {SZ_TWO,   2'd0}: begin be = 4'b1100; mdata = {b0, b1, Z, Z};   end
      {SZ_TWO,   2'd2}: begin be = 4'b0011; mdata = {b2, b3, b2, b3}; end
      {SZ_ONE,   2'd0}: begin be = 4'b1000; mdata = {b0, Z, Z, Z};    end
      {SZ_ONE,   2'd1}: begin be = 4'b0100; mdata = {b1, b1, Z, Z};   end
      {SZ_ONE,   2'd2}: begin be = 4'b0010; mdata = {b2, Z, b2, Z};   end
      {SZ_ONE,   2'd3}: begin be = 4'b0001; mdata = {b3, b3, Z, b3};  end
      default:          legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/wmirror_bridge.sv
module wmirror_bridge
  import wmb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_data,
  output logic              req_err,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [3:0]        bus_be,
  output logic [31:0]       bus_data,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic [1:0]        rd_size,
  input  logic [31:0]       rd_raw,
  output logic [31:0]       rd_data
);
  logic [CFG_W-1:0] wr_sel, rd_sel;
  logic [BUS_W-1:0] wperm;
  logic             legal;
  logic [LANES-1:0] m_be;
  logic [BUS_W-1:0] m_data;

  wmb_sel_bank u_bank (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .wr_size(req_size), .rd_size, .wr_sel, .rd_sel
  );

  wmb_lane_perm u_wperm (.din(req_data), .sel(wr_sel), .dout(wperm));
  wmb_lane_perm u_rperm (.din(rd_raw),   .sel(rd_sel), .dout(rd_data));

  wmb_mirror u_mirror (
    .size(xfer_size_e'(req_size)), .offs(req_addr[1:0]), .data(wperm),
    .legal, .be(m_be), .mdata(m_data)
  );

  // output stage: next state
  logic              vld_q, vld_d, err_q, err_d, load, accept;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  be_q;
  logic [BUS_W-1:0]  data_q;

  assign req_ready = !vld_q || bus_ready;
  assign accept    = req_valid && req_ready;

  always_comb begin
    vld_d = vld_q;
    load  = 1'b0;
    err_d = 1'b0;
    if (accept) begin
      vld_d = legal;
      load  = legal;
      err_d = !legal;
    end else if (bus_ready) begin
      vld_d = 1'b0;
    end
  end

  // output stage: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      be_q   <= '0;
      data_q <= '0;
    end else if (load) begin
      addr_q <= req_addr;
      be_q   <= m_be;
      data_q <= m_data;
    end
  end

  assign bus_valid = vld_q;
  assign req_err   = err_q;
  assign bus_addr  = addr_q;
  assign bus_be    = be_q;
  assign bus_data  = data_q;
endmodule

// File: rtl/wmb_checker.sv
module wmb_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_err,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic [31:0]       bus_data
);
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_data) && $stable(bus_be) && $stable(bus_addr)); // R6
  AST_NO_ACCEPT_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |-> !req_ready); // R7
  AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !bus_valid); // R5
  AST_ERR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> $past(req_valid && req_ready)); // R5
  AST_LANE2_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_be[1] |-> bus_data[15:8] == 8'h00); // R4
  AST_LANE3_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_be[0] |-> bus_data[7:0] == 8'h00); // R4
  AST_BE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_be != 4'b0000); // R1
endmodule

bind wmirror_bridge wmb_checker #(.ADDR_W(ADDR_W)) u_wmb_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_err(req_err), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_data(bus_data)
);

// File: tb/wmirror_bridge_bench.sv
`timescale 1ns/1ps
module wmirror_bridge_bench;
  localparam int AW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, bus_ready = 1'b1, cfg_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = '0, rd_size = '0;
  logic [31:0] req_data = '0, rd_raw = '0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic req_ready, req_err, bus_valid;
  logic [AW-1:0] bus_addr;
  logic [3:0] bus_be;
  logic [31:0] bus_data, rd_data;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wmirror_bridge #(.ADDR_W(AW)) u_wmirror_bridge (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lb(input logic [31:0] w, input int k);
    return w[31-8*k -: 8];
  endfunction

  function automatic logic [31:0] perm(input logic [31:0] w, input logic [7:0] sel);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++) r[31-8*k -: 8] = lb(w, int'(sel[2*k +: 2]));
    return r;
  endfunction

  // reference: enables from offset and length, then mirror copies
  task automatic model(input int sz, input int off, input logic [31:0] d,
                       output bit legal, output logic [3:0] be, output logic [31:0] q);
    int len = sz + 1;
    legal = (off + len <= 4) && !(sz == 1 && off % 2 == 1);
    be = '0; q = '0;
    if (!legal) return;
    for (int k = off; k < off + len; k++) begin
      be[3-k] = 1'b1;
      q[31-8*k -: 8] = lb(d, k);
    end
    if (off != 0) q[31:24] = lb(d, off);
    if (off == 3 || (sz == 1 && off == 2)) q[23:16] = lb(d, 3);
  endtask

  task automatic cfg(input int a, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic one_write(input int sz, input int off, input logic [31:0] d, input logic [7:0] wsel);
    bit lg; logic [3:0] eb; logic [31:0] ed;
    logic [AW-1:0] a = {20'hABCDE, 10'(sz * 37 + off), 2'(off)};
    model(sz, off, perm(d, wsel), lg, eb, ed);
    @(negedge clk);
    req_valid = 1; req_size = 2'(sz); req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 0;
    if (lg) begin
      chk(sz == 0 ? "R3 valid" : sz == 1 ? "R2 valid" : "R1 valid", {31'd0, bus_valid}, 1);
      chk(sz == 0 ? "R3 be" : sz == 1 ? "R2 be" : "R1 be", {28'd0, bus_be}, {28'd0, eb});
      chk("R4 data/zero lanes", bus_data, ed);
      chk("R8 addr", bus_addr, a);
      chk("R5 no err on legal", {31'd0, req_err}, 0);
    end else begin
      chk("R5 err pulse", {31'd0, req_err}, 1);
      chk("R5 no beat", {31'd0, bus_valid}, 0);
      @(negedge clk);
      chk("R5 err one cycle", {31'd0, req_err}, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [3] = '{32'h11223344, 32'hA5C3E781, 32'hFF00FE01};
    repeat (3) @(negedge clk);
    chk("R11 reset valid", {31'd0, bus_valid}, 0);
    chk("R11 reset err", {31'd0, req_err}, 0);
    chk("R11 reset ready", {31'd0, req_ready}, 1);
    rst_n = 1;
    @(negedge clk);
    rd_raw = 32'hDEADBEEF;
    for (int s = 0; s < 4; s++) begin
      rd_size = 2'(s); #0.5;
      chk("R11 read identity", rd_data, 32'hDEADBEEF);
    end

    for (int p = 0; p < 3; p++)
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 4; o++)
          one_write(s, o, pats[p], 8'hE4);

    // R9: reversing write selects for every size
    for (int s = 0; s < 4; s++) cfg(s, 8'h1B);
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++)
        one_write(s, o, 32'h0A1B2C3D, 8'h1B);   // R9
    cfg(1, 8'h4E);
    one_write(1, 0, 32'h12345678, 8'h4E);     // R9 swap pairs

    // R10: read permutation per size
    cfg(5, 8'h1B);
    cfg(7, 8'hB1);
    @(negedge clk);
    rd_raw = 32'h01234567;
    rd_size = 2'd1; #0.5; chk("R10 read size1", rd_data, perm(32'h01234567, 8'h1B));
    rd_size = 2'd3; #0.5; chk("R10 read size3", rd_data, perm(32'h01234567, 8'hB1));
    rd_size = 2'd0; #0.5; chk("R10 read size0 identity", rd_data, 32'h01234567);

    // R6/R7: stall holds the beat, back-to-back handover
    for (int s = 0; s < 4; s++) cfg(s, 8'hE4);
    @(negedge clk);
    bus_ready = 0;
    req_valid = 1; req_size = 2'd3; req_addr = 32'h100; req_data = 32'hCAFEF00D;
    @(negedge clk);
    req_size = 2'd0; req_addr = 32'h203; req_data = 32'h99887766;
    chk("R7 blocked while stalled", {31'd0, req_ready}, 0);
    repeat (3) @(negedge clk);
    chk("R6 hold data", bus_data, 32'hCAFEF00D);
    chk("R6 hold be", {28'd0, bus_be}, 32'hF);
    chk("R6 hold addr", bus_addr, 32'h100);
    chk("R6 still valid", {31'd0, bus_valid}, 1);
    bus_ready = 1;
    #0.5 chk("R7 ready on drain", {31'd0, req_ready}, 1);
    @(negedge clk);
    req_valid = 0;
    chk("R7 handover valid", {31'd0, bus_valid}, 1);
    chk("R7 handover data", bus_data, 32'h66660066);
    chk("R7 handover be", {28'd0, bus_be}, 32'h1);
    @(negedge clk);
    chk("R7 drained", {31'd0, bus_valid}, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule